// File: doc/BRIEF.md
# Frame-Sync Source Enable Selector

This block decides, every cycle, whether an external frame-sync signal may steer output alignment and which of three sync pins supplies it. The decision depends on a software enable bit, on a selection mode, and on the state of the clock-recovery loop: whether it is locked, and which numbered input clock it is using as its reference. Qualification of the sync signal and the alignment itself happen elsewhere. This block only names the source.

Three modes are provided. Fixed mode uses pin 1 whenever the loop is locked. Follow mode uses pin 1 only while the loop is locked to one input that software names. Three-pin mode ties each sync pin to particular reference inputs and picks the pin that matches the locked reference. In three-pin mode the auto-option bit changes meaning: it then decides whether a change of reference clears the enable bit by itself. The enable bit is held inside the block and can be read back.

Top module: `fsync_src_sel`

## Requirements
- R1: After reset, `sync_act_o` is 0, `sync_pin_o` is 0 and `fs_en_o` is 0.
- R2: While the enable bit is 0, `sync_act_o` is 0 and `sync_pin_o` is 0 in every mode.
- R3: In fixed mode (`mode_i` = 0) with enable set, a locked loop gives `sync_act_o` = 1 and `sync_pin_o` = 1 for any reference index. An unlocked loop gives inactive.
- R4: In follow mode (`mode_i` = 1) with enable set, pin 1 is active only while the loop is locked and `ref_idx_i` equals `auto_src_i`. Otherwise the output is inactive.
- R5: In three-pin mode (`mode_i` = 2), reference 3 selects pin 1 when `assoc_i[0]` is set, and reference 5 selects pin 1 when `assoc_i[1]` is set.
- R6: In three-pin mode, reference 4 selects pin 2 when `assoc_i[2]` is set, and reference 6 selects pin 2 when `assoc_i[3]` is set.
- R7: In three-pin mode, reference 9 always selects pin 3. An unlocked loop, or a reference with no associated pin, gives inactive with pin code 0.
- R8: In three-pin mode with `auto_clr_i` = 1, a change of `ref_idx_i` from its value on the previous cycle clears the enable bit. The cleared bit shows on `fs_en_o` and deactivates the output one cycle later.
- R9: A reference change does not clear the enable bit when `auto_clr_i` = 0 or when the mode is not three-pin.
- R10: A write (`en_wr_i` = 1) loads `en_wdata_i` into the enable bit, and it wins over an auto-clear in the same cycle.
- R11: All outputs are registered. An input change takes effect on the outputs exactly one clock edge later.
- R12: Mode code 3 is reserved and always gives inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| auto_clr_i | input | 1 | Auto-clear option (used in three-pin mode only) |
| mode_i | input | 2 | Mode: 0 fixed, 1 follow, 2 three-pin, 3 reserved |
| lock_i | input | 1 | Loop lock flag |
| ref_idx_i | input | REF_W | Number of the selected reference input |
| auto_src_i | input | REF_W | Reference number used in follow mode |
| assoc_i | input | 4 | Three-pin association mask |
| sync_act_o | output | 1 | External frame sync active |
| sync_pin_o | output | 2 | Chosen sync pin: 0 none, 1 to 3 |
| fs_en_o | output | 1 | Current enable bit |

## Verification
The assertions check on every cycle the rules that depend only on the previous cycle: an inactive output while the enable bit is clear, unlocked or in reserved mode, pin 1 in fixed mode, a mismatch in follow mode, the pin-code encoding, the auto-clear after a reference change, and a write taking priority. The bench scenarios are needed for the association table, that is, which mask bit ties which reference to which pin. They also show the sticky behaviour after a clear, where the bit stays 0 once the reference settles, and a reference change in other modes that leaves the bit alone.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED  = 2'd0,
    MODE_FOLLOW = 2'd1,
    MODE_TRIPLE = 2'd2,
    MODE_RSVD   = 2'd3
  } fs_mode_e;

  localparam int unsigned NUM_PINS = 3;
  localparam int unsigned PIN_W    = 2;
  localparam int unsigned ASSOC_W  = 4;

  localparam logic [PIN_W-1:0] PIN_NONE = 2'd0;
endpackage

// File: rtl/fsync_en_reg.sv
module fsync_en_reg #(
  parameter int unsigned REF_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wdata_i,
  input  logic             clr_arm_i,
  input  logic [REF_W-1:0] ref_idx_i,
  output logic             en_d_o,
  output logic             en_q_o
);
  logic [REF_W-1:0] ref_q;
  logic             ref_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= ref_idx_i;
  end

  assign ref_chg = (ref_idx_i != ref_q);

  // write beats auto-clear
  always_comb begin
    if (wr_i)                      en_d_o = wdata_i;
    else if (clr_arm_i && ref_chg) en_d_o = 1'b0;
    else                           en_d_o = en_q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q_o <= 1'b0;
    else         en_q_o <= en_d_o;
  end
endmodule

// File: rtl/fsync_pin_map.sv
module fsync_pin_map
  import fsync_pkg::*;
#(
  parameter int unsigned REF_W  = 4,
  parameter int unsigned IN_P1A = 3,
  parameter int unsigned IN_P1B = 5,
  parameter int unsigned IN_P2A = 4,
  parameter int unsigned IN_P2B = 6,
  parameter int unsigned IN_P3  = 9
) (
  input  logic [REF_W-1:0]   ref_idx_i,
  input  logic [ASSOC_W-1:0] assoc_i,
  output logic [NUM_PINS-1:0] hit_o
);
  localparam int unsigned REFS_PER_PIN = 2;

  // per pin: two candidate inputs, each with an enable (pin 3 fixed)
  logic [REF_W-1:0] cand [NUM_PINS][REFS_PER_PIN];
  logic             cand_en [NUM_PINS][REFS_PER_PIN];

  always_comb begin
    cand[0][0] = REF_W'(IN_P1A); cand_en[0][0] = assoc_i[0];
    cand[0][1] = REF_W'(IN_P1B); cand_en[0][1] = assoc_i[1];
    cand[1][0] = REF_W'(IN_P2A); cand_en[1][0] = assoc_i[2];
    cand[1][1] = REF_W'(IN_P2B); cand_en[1][1] = assoc_i[3];
    cand[2][0] = REF_W'(IN_P3);  cand_en[2][0] = 1'b1;
    cand[2][1] = REF_W'(IN_P3);  cand_en[2][1] = 1'b1;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [REFS_PER_PIN-1:0] m;
    for (genvar c = 0; c < REFS_PER_PIN; c++) begin : g_cand
      assign m[c] = cand_en[p][c] && (ref_idx_i == cand[p][c]);
    end
    assign hit_o[p] = |m;
  end
endmodule

// File: rtl/fsync_decide.sv
module fsync_decide
  import fsync_pkg::*;
#(
  parameter int unsigned REF_W = 4
) (
  input  logic                en_i,
  input  fs_mode_e            mode_i,
  input  logic                lock_i,
  input  logic [REF_W-1:0]    ref_idx_i,
  input  logic [REF_W-1:0]    auto_src_i,
  input  logic [NUM_PINS-1:0] hit_i,
  output logic                act_o,
  output logic [PIN_W-1:0]    pin_o
);
  logic [PIN_W-1:0] tri_pin;

  always_comb begin
    tri_pin = PIN_NONE;
    for (int p = NUM_PINS - 1; p >= 0; p--) begin
      if (hit_i[p]) tri_pin = PIN_W'(p + 1);
    end
  end

  always_comb begin
    pin_o = PIN_NONE;
    if (en_i && lock_i) begin
      unique case (mode_i)
        MODE_FIXED:  pin_o = PIN_W'(1);
        MODE_FOLLOW: pin_o = (ref_idx_i == auto_src_i) ? PIN_W'(1) : PIN_NONE;
        MODE_TRIPLE: pin_o = tri_pin;
        default:     pin_o = PIN_NONE;
      endcase
    end
    act_o = (pin_o != PIN_NONE);
  end
endmodule

// File: rtl/fsync_src_sel.sv
module fsync_src_sel
  import fsync_pkg::*;
#(
  parameter int unsigned REF_W  = 4,
  parameter int unsigned IN_P1A = 3,
  parameter int unsigned IN_P1B = 5,
  parameter int unsigned IN_P2A = 4,
  parameter int unsigned IN_P2B = 6,
  parameter int unsigned IN_P3  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_wr_i,
  input  logic             en_wdata_i,
  input  logic             auto_clr_i,
  input  logic [1:0]       mode_i,
  input  logic             lock_i,
  input  logic [REF_W-1:0] ref_idx_i,
  input  logic [REF_W-1:0] auto_src_i,
  input  logic [3:0]       assoc_i,
  output logic             sync_act_o,
  output logic [1:0]       sync_pin_o,
  output logic             fs_en_o
);
  fs_mode_e            mode;
  logic                en_d;
  logic                clr_arm;
  logic [NUM_PINS-1:0] hit;
  logic                act_d;
  logic [PIN_W-1:0]    pin_d;

  assign mode    = fs_mode_e'(mode_i);
  assign clr_arm = (mode == MODE_TRIPLE) && auto_clr_i;

  fsync_en_reg #(.REF_W(REF_W)) u_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (en_wr_i),
    .wdata_i   (en_wdata_i),
    .clr_arm_i (clr_arm),
    .ref_idx_i (ref_idx_i),
    .en_d_o    (en_d),
    .en_q_o    (fs_en_o)
  );

  fsync_pin_map #(
    .REF_W(REF_W), .IN_P1A(IN_P1A), .IN_P1B(IN_P1B),
    .IN_P2A(IN_P2A), .IN_P2B(IN_P2B), .IN_P3(IN_P3)
  ) u_map (
    .ref_idx_i (ref_idx_i),
    .assoc_i   (assoc_i),
    .hit_o     (hit)
  );

  fsync_decide #(.REF_W(REF_W)) u_dec (
    .en_i       (en_d),
    .mode_i     (mode),
    .lock_i     (lock_i),
    .ref_idx_i  (ref_idx_i),
    .auto_src_i (auto_src_i),
    .hit_i      (hit),
    .act_o      (act_d),
    .pin_o      (pin_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_act_o <= 1'b0;
      sync_pin_o <= PIN_NONE;
    end else begin
      sync_act_o <= act_d;
      sync_pin_o <= pin_d;
    end
  end
endmodule

// File: rtl/fsync_src_sel_chk.sv
module fsync_src_sel_chk #(
  parameter int unsigned REF_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_wr_i,
  input logic             en_wdata_i,
  input logic             auto_clr_i,
  input logic [1:0]       mode_i,
  input logic             lock_i,
  input logic [REF_W-1:0] ref_idx_i,
  input logic [REF_W-1:0] auto_src_i,
  input logic             sync_act_o,
  input logic [1:0]       sync_pin_o,
  input logic             fs_en_o
);
  logic [1:0] seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == 2'd0) |-> (!sync_act_o && sync_pin_o == 2'd0 && !fs_en_o));

  a_r2_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_en_o |-> !sync_act_o);

  a_r3_fixed_pin1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0 && fs_en_o && $past(mode_i == 2'd0 && lock_i))
      |-> (sync_act_o && sync_pin_o == 2'd1));

  a_r4_follow_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0 && $past(mode_i == 2'd1 && ref_idx_i != auto_src_i)) |-> !sync_act_o);

  a_r7_unlocked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0 && $past(!lock_i)) |-> !sync_act_o);

  a_r7_pin_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_act_o == (sync_pin_o != 2'd0));

  a_r8_auto_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == 2'd3 && $past(mode_i == 2'd2 && auto_clr_i && !en_wr_i)
      && $past(ref_idx_i) != $past(ref_idx_i, 2)) |-> !fs_en_o);

  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0 && $past(en_wr_i)) |-> (fs_en_o == $past(en_wdata_i)));

  a_r12_reserved_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0 && $past(mode_i == 2'd3)) |-> !sync_act_o);
endmodule

bind fsync_src_sel fsync_src_sel_chk #(.REF_W(REF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_wr_i    (en_wr_i),
  .en_wdata_i (en_wdata_i),
  .auto_clr_i (auto_clr_i),
  .mode_i     (mode_i),
  .lock_i     (lock_i),
  .ref_idx_i  (ref_idx_i),
  .auto_src_i (auto_src_i),
  .sync_act_o (sync_act_o),
  .sync_pin_o (sync_pin_o),
  .fs_en_o    (fs_en_o)
);

// File: tb/fsync_src_sel_tb.sv
module fsync_src_sel_tb;
  localparam int REF_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_wr_i = 1'b0, en_wdata_i = 1'b0, auto_clr_i = 1'b0, lock_i = 1'b0;
  logic [1:0]       mode_i = 2'd0;
  logic [REF_W-1:0] ref_idx_i = '0, auto_src_i = '0;
  logic [3:0]       assoc_i = '0;
  logic             sync_act_o, fs_en_o;
  logic [1:0]       sync_pin_o;

  always #2.5 clk_i = ~clk_i;

  fsync_src_sel #(.REF_W(REF_W)) u_dut (.*);

  typedef struct {
    int         stamp;
    logic       act;
    logic [1:0] pin;
    logic       en;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0, n_bad = 0;
  logic m_en = 1'b0;
  logic [REF_W-1:0] m_ref = '0;
  bit   done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // reference model built from the requirements
  task automatic apply(input string tag, input logic wr, input logic wd, input logic [1:0] md,
                       input logic aclr, input logic lk, input logic [REF_W-1:0] rf,
                       input logic [REF_W-1:0] src, input logic [3:0] msk);
    exp_t e;
    logic nen;
    logic [1:0] p;
    @(posedge clk_i);
    #1;
    en_wr_i = wr; en_wdata_i = wd; mode_i = md; auto_clr_i = aclr;
    lock_i = lk; ref_idx_i = rf; auto_src_i = src; assoc_i = msk;
    if (wr) nen = wd;
    else if (md == 2'd2 && aclr && rf != m_ref) nen = 1'b0;
    else nen = m_en;
    p = 2'd0;
    if (nen && lk) begin
      case (md)
        2'd0: p = 2'd1;
        2'd1: p = (rf == src) ? 2'd1 : 2'd0;
        2'd2: begin
          if ((rf == 3 && msk[0]) || (rf == 5 && msk[1])) p = 2'd1;
          else if ((rf == 4 && msk[2]) || (rf == 6 && msk[3])) p = 2'd2;
          else if (rf == 9) p = 2'd3;
        end
        default: p = 2'd0;
      endcase
    end
    m_en = nen; m_ref = rf;
    e.stamp = cyc; e.act = (p != 0); e.pin = p; e.en = nen; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      #3;
      while (q.size() > 0 && q[0].stamp < cyc) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (sync_act_o !== e.act || sync_pin_o !== e.pin || fs_en_o !== e.en) begin
          n_bad++;
          $display("FAIL %s: act/pin/en got %0b/%0d/%0b exp %0b/%0d/%0b",
                   e.tag, sync_act_o, sync_pin_o, fs_en_o, e.act, e.pin, e.en);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    n_chk++;
    if (sync_act_o !== 1'b0 || sync_pin_o !== 2'd0 || fs_en_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: act/pin/en got %0b/%0d/%0b exp 0/0/0", sync_act_o, sync_pin_o, fs_en_o);
    end
    // disabled, every mode
    apply("R2 fixed disabled",  0, 0, 2'd0, 0, 1, 4'd7, 4'd0, 4'h0);
    apply("R2 triple disabled", 0, 0, 2'd2, 0, 1, 4'd9, 4'd0, 4'hF);
    // fixed mode
    apply("R3 R10 fixed write", 1, 1, 2'd0, 0, 1, 4'd7, 4'd0, 4'h0);
    apply("R3 fixed other ref", 0, 0, 2'd0, 0, 1, 4'd2, 4'd0, 4'h0);
    apply("R3 fixed unlocked",  0, 0, 2'd0, 0, 0, 4'd2, 4'd0, 4'h0);
    apply("R11 fixed relock",   0, 0, 2'd0, 0, 1, 4'd2, 4'd0, 4'h0);
    // follow mode; ref changes with auto_clr set must not clear
    apply("R4 R9 follow match", 0, 0, 2'd1, 1, 1, 4'd4, 4'd4, 4'h0);
    apply("R4 R9 follow miss",  0, 0, 2'd1, 1, 1, 4'd5, 4'd4, 4'h0);
    apply("R4 follow unlocked", 0, 0, 2'd1, 0, 0, 4'd4, 4'd4, 4'h0);
    // three-pin, no auto-clear
    apply("R5 R9 ref3 mask0",   0, 0, 2'd2, 0, 1, 4'd3, 4'd0, 4'b0001);
    apply("R5 ref5 unmapped",   0, 0, 2'd2, 0, 1, 4'd5, 4'd0, 4'b0001);
    apply("R5 ref5 mask1",      0, 0, 2'd2, 0, 1, 4'd5, 4'd0, 4'b0011);
    apply("R5 ref3 mask1 only", 0, 0, 2'd2, 0, 1, 4'd3, 4'd0, 4'b0010);
    apply("R6 ref4 mask2",      0, 0, 2'd2, 0, 1, 4'd4, 4'd0, 4'b0100);
    apply("R6 ref6 mask3",      0, 0, 2'd2, 0, 1, 4'd6, 4'd0, 4'b1000);
    apply("R6 ref6 mask2 only", 0, 0, 2'd2, 0, 1, 4'd6, 4'd0, 4'b0100);
    apply("R7 ref9 no mask",    0, 0, 2'd2, 0, 1, 4'd9, 4'd0, 4'b0000);
    apply("R7 ref1 none",       0, 0, 2'd2, 0, 1, 4'd1, 4'd0, 4'hF);
    apply("R7 ref9 unlocked",   0, 0, 2'd2, 0, 0, 4'd9, 4'd0, 4'hF);
    apply("R12 reserved mode",  0, 0, 2'd3, 0, 1, 4'd9, 4'd9, 4'hF);
    // auto-clear
    apply("R8 triple steady",   0, 0, 2'd2, 1, 1, 4'd9, 4'd0, 4'hF);
    apply("R8 ref change clr",  0, 0, 2'd2, 1, 1, 4'd3, 4'd0, 4'hF);
    apply("R8 clear sticky",    0, 0, 2'd2, 1, 1, 4'd3, 4'd0, 4'hF);
    apply("R10 write vs clear", 1, 1, 2'd2, 1, 1, 4'd4, 4'd0, 4'hF);
    apply("R8 clear again",     0, 0, 2'd2, 1, 1, 4'd9, 4'd0, 4'hF);
    apply("R10 write enable",   1, 1, 2'd2, 0, 1, 4'd9, 4'd0, 4'hF);
    apply("R9 no aclr change",  0, 0, 2'd2, 0, 1, 4'd6, 4'd0, 4'hF);
    apply("R10 write zero",     1, 0, 2'd0, 0, 1, 4'd6, 4'd0, 4'hF);
    apply("R2 after clear",     0, 0, 2'd0, 0, 1, 4'd6, 4'd0, 4'hF);
    repeat (3) @(posedge clk_i);
    #4;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule